// File: doc/BRIEF.md
# Strobed Output Port Handshake

This block holds one byte written by a host and offers it to a peripheral under a two-wire handshake. A selected host write loads the byte into an output register. When the host releases its write strobe, an active-low buffer-full line tells the peripheral that fresh data is waiting. The peripheral takes the byte and pulls its active-low acknowledge line. The buffer-full line then returns high, and the rising edge of acknowledge can raise an interrupt that asks the host for the next byte.

The interrupt is gated by an internal enable flip-flop. That flip-flop is written by a single-bit set/clear command that addresses one of eight port-C bit positions. The default position is 6, and the position is a parameter, so the same block serves a port that uses position 2. An interrupt is raised only when the acknowledge finishes a transfer that was actually pending. The interrupt is withdrawn as soon as the host starts its next write to the port. Every input is sampled on the clock, and every output is a register.

Top module: `strobed_out_port`

## Requirements
- R1: While reset is asserted and after it is released, obfN is 1, intr is 0 and portOut is 0. The interrupt enable is cleared by reset, so a write followed by an acknowledge does not raise intr until the enable has been set.
- R2: On each clock edge at which wrN is 0 and portSel is 1, portOut loads wrData. At the first edge at which wrN is back at 1, obfN goes to 0. That fall happens only when portSel was 1 in the last low cycle of the strobe.
- R3: A strobe on wrN while portSel is 0 changes neither portOut nor obfN.
- R4: On each clock edge at which ackN is 0, obfN goes to 1, unless a selected write completes at that same edge.
- R5: portOut keeps its value through the acknowledge and until the next selected write.
- R6: At the first edge at which ackN is back at 1, intr goes to 1 if all three of these hold: the interrupt enable is set, obfN is 1, and obfN was 0 at some edge while ackN was low.
- R7: An acknowledge pulse that begins while obfN is already 1 does not raise intr, even with the enable set.
- R8: intr goes to 0 at the edge at which a selected wrN is first seen low.
- R9: A command with bitCmd=1 and bitIdx equal to INTE_BIT (default 6) writes bitVal into the interrupt enable. Writing 0 also drops intr at that edge. A command with any other bitIdx has no effect on the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrN | input | 1 | Host write strobe, active low |
| portSel | input | 1 | Host selects this port during the strobe |
| wrData | input | DATA_W | Byte presented by the host |
| bitCmd | input | 1 | One-cycle bit set/clear command |
| bitIdx | input | IDX_W | Port-C bit position the command addresses |
| bitVal | input | 1 | Value written by the command |
| ackN | input | 1 | Peripheral acknowledge, active low |
| portOut | output | DATA_W | Latched output byte |
| obfN | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request to the host |

## Verification
Every result is due one clock edge after the input condition is sampled. portOut follows the edge that sees a selected low strobe. obfN falls at the edge that sees the strobe high again, and rises at the edge that sees ackN low. intr rises at the edge that sees ackN high again, falls at the edge that sees a selected strobe go low, and follows an enable command at the next edge. The bench changes inputs only on falling clock edges, lets exactly one rising edge pass, and checks at the following falling edge. It sweeps all 256 data values, toggling the enable as it goes, and then sweeps all eight command bit positions.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;
  } sopStrobe_t;

endpackage

// File: rtl/sop_datapath.sv
module sop_datapath #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sop_pkg::sopStrobe_t  strobes,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    portOut
);

  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobes.loadData) begin
      dataReg <= wrData;
    end
  end

  assign portOut = dataReg;

  // Output byte only moves on a load strobe (R5)
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadData |=> $stable(portOut));

  // Loaded value appears at the next edge (R2)
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadData |=> (portOut == $past(wrData)));

endmodule

// File: rtl/sop_ctrl.sv
module sop_ctrl #(
  parameter int IDX_W    = 3,
  parameter int INTE_BIT = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrN,
  input  logic                 portSel,
  input  logic                 bitCmd,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic                 bitVal,
  input  logic                 ackN,
  output sop_pkg::sopStrobe_t  strobes,
  output logic                 obfN,
  output logic                 intr
);

  localparam logic [IDX_W-1:0] ENABLE_POS = IDX_W'(INTE_BIT);

  logic wrNQ;
  logic selQ;
  logic ackNQ;
  logic ackArmed;
  logic inte;
  logic obfReg;
  logic intrReg;

  logic wrFall;
  logic wrRise;
  logic ackLow;
  logic ackRise;
  logic inteHit;

  always_comb begin
    wrFall           = !wrN && wrNQ && portSel;
    wrRise           = wrN && !wrNQ && selQ;
    ackLow           = !ackN;
    ackRise          = ackN && !ackNQ;
    inteHit          = bitCmd && (bitIdx == ENABLE_POS);
    strobes.loadData = !wrN && portSel;
  end

  // Edge history, idle high so reset never fakes an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrNQ  <= 1'b1;
      selQ  <= 1'b0;
      ackNQ <= 1'b1;
    end else begin
      wrNQ  <= wrN;
      selQ  <= portSel;
      ackNQ <= ackN;
    end
  end

  // Buffer-full line: write completion wins over a concurrent acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfReg <= 1'b1;
    end else if (wrRise) begin
      obfReg <= 1'b0;
    end else if (ackLow) begin
      obfReg <= 1'b1;
    end
  end

  // Remembers that this acknowledge pulse served a pending byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackArmed <= 1'b0;
    end else if (ackRise) begin
      ackArmed <= 1'b0;
    end else if (ackLow && !obfReg) begin
      ackArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inte <= 1'b0;
    end else if (inteHit) begin
      inte <= bitVal;
    end
  end

  // Interrupt: clearing has priority over setting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrReg <= 1'b0;
    end else if (wrFall || (inteHit && !bitVal)) begin
      intrReg <= 1'b0;
    end else if (ackRise && ackArmed && inte && obfReg) begin
      intrReg <= 1'b1;
    end
  end

  assign obfN = obfReg;
  assign intr = intrReg;

  assert_obf_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrRise |=> !obfN);

  assert_obf_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackLow && !wrRise) |=> obfN);

  assert_intr_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intr) |-> (inte && obfN));

  assert_intr_on_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intr) |-> ($past(ackN) && !$past(ackNQ)));

  assert_intr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrFall |=> !intr);

  assert_inte_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inteHit && !bitVal) |=> (!intr && !inte));

endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int INTE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              portSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitCmd,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              bitVal,
  input  logic              ackN,
  output logic [DATA_W-1:0] portOut,
  output logic              obfN,
  output logic              intr
);

  sop_pkg::sopStrobe_t strobes;

  sop_ctrl #(
    .IDX_W    (IDX_W),
    .INTE_BIT (INTE_BIT)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrN     (wrN),
    .portSel (portSel),
    .bitCmd  (bitCmd),
    .bitIdx  (bitIdx),
    .bitVal  (bitVal),
    .ackN    (ackN),
    .strobes (strobes),
    .obfN    (obfN),
    .intr    (intr)
  );

  sop_datapath #(
    .DATA_W (DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .portOut (portOut)
  );

endmodule

// File: tb/sim_strobed_out_port.sv
`timescale 1ns/100ps
module sim_strobed_out_port;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrN;
  logic       portSel;
  logic [7:0] wrData;
  logic       bitCmd;
  logic [2:0] bitIdx;
  logic       bitVal;
  logic       ackN;
  logic [7:0] portOut;
  logic       obfN;
  logic       intr;

  int checks = 0;
  int errors = 0;
  logic expInte;
  logic expIntr;

  always #2.5 clk = ~clk;

  strobed_out_port u0 (
    .clk(clk), .rstN(rstN), .wrN(wrN), .portSel(portSel), .wrData(wrData),
    .bitCmd(bitCmd), .bitIdx(bitIdx), .bitVal(bitVal), .ackN(ackN),
    .portOut(portOut), .obfN(obfN), .intr(intr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bitCommand(input logic [2:0] idx, input logic val);
    bitCmd = 1'b1; bitIdx = idx; bitVal = val;
    tick();
    bitCmd = 1'b0;
  endtask

  task automatic fullWrite(input logic [7:0] d);
    portSel = 1'b1; wrData = d; wrN = 1'b0;
    tick();
    wrN = 1'b1;
    tick();
    portSel = 1'b0;
  endtask

  task automatic ackPulse();
    ackN = 1'b0;
    tick();
    ackN = 1'b1;
    tick();
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrN = 1'b1; portSel = 1'b0; wrData = 8'h00;
    bitCmd = 1'b0; bitIdx = 3'd0; bitVal = 1'b0; ackN = 1'b1;
    tick(); tick();
    // R1 during reset
    chk("R1 obfN in reset", int'(obfN), 1);
    chk("R1 intr in reset", int'(intr), 0);
    chk("R1 portOut in reset", int'(portOut), 0);
    rstN = 1'b1;
    tick();
    chk("R1 obfN after reset", int'(obfN), 1);
    chk("R1 portOut after reset", int'(portOut), 0);

    // R1: enable cleared by reset
    fullWrite(8'h5A);
    ackPulse();
    chk("R1 no intr with reset enable", int'(intr), 0);

    // R7: enable set, acknowledge with nothing pending
    bitCommand(3'd6, 1'b1);
    expInte = 1'b1; expIntr = 1'b0;
    ackPulse();
    chk("R7 no intr without pending byte", int'(intr), 0);
    chk("R7 obfN stays high", int'(obfN), 1);

    // Sweep every data value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      bitCommand(3'd6, d[1]);
      expInte = d[1];
      if (!d[1]) expIntr = 1'b0;
      chk("R9 intr after enable command", int'(intr), int'(expIntr));

      portSel = 1'b1; wrData = d; wrN = 1'b0;
      tick();
      expIntr = 1'b0;
      chk("R2 portOut loads", int'(portOut), int'(d));
      chk("R8 intr cleared by strobe", int'(intr), 0);
      chk("R2 obfN high during strobe", int'(obfN), 1);
      wrN = 1'b1;
      tick();
      portSel = 1'b0;
      chk("R2 obfN low after strobe", int'(obfN), 0);

      wrData = ~d; wrN = 1'b0;
      tick();
      wrN = 1'b1;
      tick();
      chk("R3 portOut unchanged", int'(portOut), int'(d));
      chk("R3 obfN unchanged", int'(obfN), 0);

      ackN = 1'b0;
      tick();
      chk("R4 obfN high on ack", int'(obfN), 1);
      chk("R5 portOut held on ack", int'(portOut), int'(d));
      ackN = 1'b1;
      tick();
      expIntr = expInte;
      chk("R6 intr on ack rise", int'(intr), int'(expIntr));
      chk("R5 portOut held after ack", int'(portOut), int'(d));
    end

    // Sweep command bit positions
    for (int idx = 0; idx < 8; idx++) begin
      bitCommand(3'd6, 1'b0);
      chk("R9 intr dropped by clear", int'(intr), 0);
      bitCommand(3'(idx), 1'b1);
      fullWrite(8'(idx + 16));
      ackPulse();
      chk("R9 enable only at position 6", int'(intr), (idx == 6) ? 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule